// File: doc/BRIEF.md
# Time-Shared Multichannel Tuner

This block tunes many narrowband receiver channels with one oscillator and one complex multiplier. An upstream filter bank splits a wide band into equally spaced frequency bins. Each bin arrives at the input rate divided by the bin count. Once per frame, the bank writes one complex sample for every bin into an on-chip bin buffer. It then pulses `frame_start`.

Each logical channel has three pieces of state: a bin selector, a 32-bit tuning step, and a 32-bit phase accumulator held in a small RAM. After a frame is accepted, a slot counter visits channels 0 to NCH-1, one per clock. In its slot, a channel does the following in order:
- It fetches the latest sample of its chosen bin.
- It reads its phase and looks up a cosine and a sine from the top 10 phase bits.
- It multiplies the sample by the conjugate oscillator, which moves the tuned frequency inside the bin to 0 Hz.
- It writes the advanced phase back.

The result leaves the block as a complex sample tagged with its channel number. Because consecutive slots always address different channels, the read-modify-write of the phase RAM needs no forwarding path.

Channels are configured through a simple write port. Field code 0 selects the tuning step, 1 the bin selector, and 2 a phase-clear command. Every write takes effect at that channel's next slot.

Top module: `ts_tuner`

## Requirements
- R1: After reset, `out_valid` is 0. Every channel has tuning step 0 and bin selector 0, and its first slot uses phase 0.
- R2: Suppose `frame_start` is sampled high at a rising edge E while no sweep is running. Then exactly NCH outputs follow, one per cycle. The output for channel c is valid after rising edge E+c+3, and `out_valid` is 0 at all other times.
- R3: `frame_start` is ignored at the NCH rising edges that follow an accepted edge. Held high, it is therefore accepted every NCH+1 edges.
- R4: A slot uses the channel's accumulator value before the advance. After the slot, the accumulator holds that value plus the tuning step modulo 2^32. The sum wraps with no reset, and the residue is kept.
- R5: The oscillator index is phase bits [31:22], called k. Cosine is round(32767·cos(2πk/1024)) and sine is round(32767·sin(2πk/1024)), rounding half away from zero.
- R6: The sample is I + jQ and the table outputs are C and S. The output is I·C + Q·S on the I arm and Q·C − I·S on the Q arm. Each arm adds 2^14 to its sum, shifts right arithmetically by 15, and saturates to [−32768, 32767].
- R7: A write with `bin_we` stores (`bin_i`, `bin_q`) at index `bin_idx`. A channel's input is the stored entry at its bin selector. The selector takes the low log2(NBIN) bits of `cfg_data`.
- R8: `cfg_field` codes are: 0 tuning step, 1 bin selector, 2 phase clear (when `cfg_data[0]` is 1). Code 3 changes nothing. A write made while no sweep runs takes effect at that channel's next slot.
- R9: After a phase-clear command, the channel's next slot uses phase 0. Its accumulator then holds exactly its tuning step. A clear write with `cfg_data[0]` = 0 has no effect.
- R10: `out_ch` carries the index of the channel whose result is on `out_i`/`out_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | All bins of a new frame are stored; start a sweep |
| bin_we | input | 1 | Bin buffer write strobe |
| bin_idx | input | log2(NBIN) | Bin buffer write index |
| bin_i | input | 16 | In-phase part of the bin sample |
| bin_q | input | 16 | Quadrature part of the bin sample |
| cfg_we | input | 1 | Channel configuration write strobe |
| cfg_ch | input | log2(NCH) | Channel addressed by the write |
| cfg_field | input | 2 | 0 step, 1 bin selector, 2 phase clear, 3 none |
| cfg_data | input | 32 | Write data |
| out_valid | output | 1 | Output sample strobe |
| out_ch | output | log2(NCH) | Channel tag of the output |
| out_i | output | 16 | Tuned in-phase output |
| out_q | output | 16 | Tuned quadrature output |

## Verification
The assertions check the following on every cycle:
- The slot counter steps by one through the channels.
- A `frame_start` during a sweep never restarts it.
- Each output appears exactly three cycles after its slot, carrying that slot's channel tag.
- A cleared phase always reaches the mixer as a zero angle.

The numeric results can only be shown by the bench's scenarios. These results include the oscillator values and the rounding and saturation of the mixer. They also include phase wrap with residue across frames, bin selection with masked upper bits, inert field code 3 writes, and the back-to-back sweeps seen when `frame_start` is held high.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

  localparam int SAMP_W = 16;
  localparam int ACC_W  = 2 * SAMP_W + 2;
  localparam int PIPE_RMW = 2;

  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (SAMP_W - 2);
  localparam logic signed [ACC_W-1:0] POS_MAX  = (ACC_W'(1) <<< (SAMP_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] NEG_MIN  = -(ACC_W'(1) <<< (SAMP_W - 1));

  localparam real TWO_PI = 6.283185307179586;

  typedef enum logic [1:0] {
    FLD_STEP  = 2'd0,
    FLD_BSEL  = 2'd1,
    FLD_CLEAR = 2'd2,
    FLD_NONE  = 2'd3
  } cfg_field_e;

  // one oscillator table entry, amplitude full-scale minus one, round half away from zero
  function automatic logic signed [SAMP_W-1:0] wave_entry(input int k, input int n, input bit want_sin);
    real ang;
    real v;
    int  r;
    ang = TWO_PI * real'(k) / real'(n);
    v   = want_sin ? $sin(ang) : $cos(ang);
    v   = v * real'((1 << (SAMP_W - 1)) - 1);
    r   = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    return SAMP_W'(r);
  endfunction

  // one mixer arm: a*b + d*c, or a*b - d*c when neg is set; rounded and saturated
  function automatic logic signed [SAMP_W-1:0] mix_arm(
    input logic signed [SAMP_W-1:0] a,
    input logic signed [SAMP_W-1:0] b,
    input logic signed [SAMP_W-1:0] c,
    input logic signed [SAMP_W-1:0] d,
    input logic                     neg
  );
    logic signed [ACC_W-1:0] p0;
    logic signed [ACC_W-1:0] p1;
    logic signed [ACC_W-1:0] s;
    logic signed [ACC_W-1:0] t;
    p0 = ACC_W'(a) * ACC_W'(b);
    p1 = ACC_W'(d) * ACC_W'(c);
    s  = neg ? (p0 - p1) : (p0 + p1);
    t  = (s + HALF_LSB) >>> (SAMP_W - 1);
    if (t > POS_MAX)      return POS_MAX[SAMP_W-1:0];
    else if (t < NEG_MIN) return NEG_MIN[SAMP_W-1:0];
    else                  return t[SAMP_W-1:0];
  endfunction

endpackage

// File: rtl/tuner_slot_seq.sv
module tuner_slot_seq #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  output logic           issue_vld,
  output logic [CHW-1:0] issue_ch
);

  logic           running;
  logic [CHW-1:0] slot;
  logic           at_last;

  assign at_last = (slot == CHW'(NCH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      slot    <= '0;
    end else if (!running) begin
      slot <= '0;
      if (frame_start) running <= 1'b1;
    end else if (at_last) begin
      running <= 1'b0;
      slot    <= '0;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  assign issue_vld = running;
  assign issue_ch  = slot;

endmodule

// File: rtl/tuner_chan_cfg.sv
module tuner_chan_cfg import tuner_pkg::*; #(
  parameter int NCH  = 8,
  parameter int CHW  = 3,
  parameter int BINW = 6,
  parameter int PW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [1:0]      cfg_field,
  input  logic [PW-1:0]   cfg_data,
  input  logic            take,
  input  logic [CHW-1:0]  rd_ch,
  output logic [PW-1:0]   rd_step,
  output logic [BINW-1:0] rd_bsel,
  output logic            rd_clr
);

  logic [PW-1:0]   step_a [NCH];
  logic [BINW-1:0] bsel_a [NCH];
  logic            clr_a  [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic            hit;
    logic            used;
    logic [PW-1:0]   step_r;
    logic [BINW-1:0] bsel_r;
    logic            clr_r;

    assign hit  = cfg_we && (cfg_ch == CHW'(c));
    assign used = take && (rd_ch == CHW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        step_r <= '0;
        bsel_r <= '0;
        clr_r  <= 1'b1;
      end else begin
        if (hit && cfg_field == FLD_STEP) step_r <= cfg_data;
        if (hit && cfg_field == FLD_BSEL) bsel_r <= cfg_data[BINW-1:0];
        if (hit && cfg_field == FLD_CLEAR && cfg_data[0]) clr_r <= 1'b1;
        else if (used)                                    clr_r <= 1'b0;
      end
    end

    assign step_a[c] = step_r;
    assign bsel_a[c] = bsel_r;
    assign clr_a[c]  = clr_r;
  end

  assign rd_step = step_a[rd_ch];
  assign rd_bsel = bsel_a[rd_ch];
  assign rd_clr  = clr_a[rd_ch];

endmodule

// File: rtl/tuner_nco.sv
module tuner_nco import tuner_pkg::*; #(
  parameter int NCH    = 8,
  parameter int CHW    = 3,
  parameter int PW     = 32,
  parameter int LUT_AW = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s0_vld,
  input  logic [CHW-1:0]           s0_ch,
  input  logic [PW-1:0]            s0_step,
  input  logic                     s0_clr,
  output logic signed [SAMP_W-1:0] cos_q,
  output logic signed [SAMP_W-1:0] sin_q,
  output logic                     cleared
);

  localparam int LUT_N = 1 << LUT_AW;

  logic [PW-1:0]  phase_mem [NCH];
  logic [PW-1:0]  rd_q;
  logic [PW-1:0]  step1;
  logic           clr1;
  logic           v1;
  logic [CHW-1:0] ch1;
  logic [PW-1:0]  cur_phase;
  logic [LUT_AW-1:0] lut_idx;

  logic signed [SAMP_W-1:0] cos_tab [LUT_N];
  logic signed [SAMP_W-1:0] sin_tab [LUT_N];

  for (genvar k = 0; k < LUT_N; k++) begin : g_lut
    localparam logic signed [SAMP_W-1:0] CV = wave_entry(k, LUT_N, 1'b0);
    localparam logic signed [SAMP_W-1:0] SV = wave_entry(k, LUT_N, 1'b1);
    assign cos_tab[k] = CV;
    assign sin_tab[k] = SV;
  end

  // phase RAM: read in slot stage, write back one stage later
  always_ff @(posedge clk) begin
    if (s0_vld) rd_q <= phase_mem[s0_ch];
    if (v1)     phase_mem[ch1] <= cur_phase + step1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      ch1   <= '0;
      step1 <= '0;
      clr1  <= 1'b0;
    end else begin
      v1 <= s0_vld;
      if (s0_vld) begin
        ch1   <= s0_ch;
        step1 <= s0_step;
        clr1  <= s0_clr;
      end
    end
  end

  assign cur_phase = clr1 ? '0 : rd_q;
  assign lut_idx   = cur_phase[PW-1 -: LUT_AW];
  assign cleared   = v1 && clr1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cos_q <= '0;
      sin_q <= '0;
    end else if (v1) begin
      cos_q <= cos_tab[lut_idx];
      sin_q <= sin_tab[lut_idx];
    end
  end

endmodule

// File: rtl/tuner_mixer.sv
module tuner_mixer import tuner_pkg::*; #(
  parameter int CHW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic [CHW-1:0]           in_ch,
  input  logic signed [SAMP_W-1:0] in_i,
  input  logic signed [SAMP_W-1:0] in_q,
  input  logic signed [SAMP_W-1:0] lo_cos,
  input  logic signed [SAMP_W-1:0] lo_sin,
  output logic                     out_valid,
  output logic [CHW-1:0]           out_ch,
  output logic signed [SAMP_W-1:0] out_i,
  output logic signed [SAMP_W-1:0] out_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_vld;
      if (in_vld) begin
        out_ch <= in_ch;
        out_i  <= mix_arm(in_i, lo_cos, lo_sin, in_q, 1'b0);
        out_q  <= mix_arm(in_q, lo_cos, lo_sin, in_i, 1'b1);
      end
    end
  end

endmodule

// File: rtl/ts_tuner.sv
module ts_tuner import tuner_pkg::*; #(
  parameter int NCH    = 8,
  parameter int NBIN   = 64,
  parameter int PW     = 32,
  parameter int LUT_AW = 10,
  localparam int CHW   = (NCH  > 1) ? $clog2(NCH)  : 1,
  localparam int BINW  = (NBIN > 1) ? $clog2(NBIN) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     bin_we,
  input  logic [BINW-1:0]          bin_idx,
  input  logic signed [SAMP_W-1:0] bin_i,
  input  logic signed [SAMP_W-1:0] bin_q,
  input  logic                     cfg_we,
  input  logic [CHW-1:0]           cfg_ch,
  input  logic [1:0]               cfg_field,
  input  logic [PW-1:0]            cfg_data,
  output logic                     out_valid,
  output logic [CHW-1:0]           out_ch,
  output logic signed [SAMP_W-1:0] out_i,
  output logic signed [SAMP_W-1:0] out_q
);

  if (NCH < PIPE_RMW) begin : g_bad_nch
    $error("ts_tuner: NCH must cover the phase read-modify-write depth");
  end
  if (LUT_AW > PW) begin : g_bad_lut
    $error("ts_tuner: LUT_AW must not exceed PW");
  end

  logic                     issue_vld;
  logic [CHW-1:0]           issue_ch;
  logic [PW-1:0]            sel_step;
  logic [BINW-1:0]          sel_bin;
  logic                     sel_clr;
  logic signed [SAMP_W-1:0] lut_cos;
  logic signed [SAMP_W-1:0] lut_sin;
  logic                     ph_cleared;

  logic [2*SAMP_W-1:0] bin_mem [NBIN];
  logic [2*SAMP_W-1:0] samp1;
  logic [2*SAMP_W-1:0] samp2;
  logic                v1;
  logic                v2;
  logic [CHW-1:0]      ch1;
  logic [CHW-1:0]      ch2;

  tuner_slot_seq #(.NCH(NCH), .CHW(CHW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .issue_vld   (issue_vld),
    .issue_ch    (issue_ch)
  );

  tuner_chan_cfg #(.NCH(NCH), .CHW(CHW), .BINW(BINW), .PW(PW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_ch    (cfg_ch),
    .cfg_field (cfg_field),
    .cfg_data  (cfg_data),
    .take      (issue_vld),
    .rd_ch     (issue_ch),
    .rd_step   (sel_step),
    .rd_bsel   (sel_bin),
    .rd_clr    (sel_clr)
  );

  tuner_nco #(.NCH(NCH), .CHW(CHW), .PW(PW), .LUT_AW(LUT_AW)) u_nco (
    .clk     (clk),
    .rst_n   (rst_n),
    .s0_vld  (issue_vld),
    .s0_ch   (issue_ch),
    .s0_step (sel_step),
    .s0_clr  (sel_clr),
    .cos_q   (lut_cos),
    .sin_q   (lut_sin),
    .cleared (ph_cleared)
  );

  // bin buffer and sample alignment with the oscillator pipeline
  always_ff @(posedge clk) begin
    if (bin_we)    bin_mem[bin_idx] <= {bin_i, bin_q};
    if (issue_vld) samp1 <= bin_mem[sel_bin];
    if (v1)        samp2 <= samp1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1  <= 1'b0;
      v2  <= 1'b0;
      ch1 <= '0;
      ch2 <= '0;
    end else begin
      v1 <= issue_vld;
      v2 <= v1;
      if (issue_vld) ch1 <= issue_ch;
      if (v1)        ch2 <= ch1;
    end
  end

  tuner_mixer #(.CHW(CHW)) u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (v2),
    .in_ch     (ch2),
    .in_i      ($signed(samp2[2*SAMP_W-1 -: SAMP_W])),
    .in_q      ($signed(samp2[SAMP_W-1:0])),
    .lo_cos    (lut_cos),
    .lo_sin    (lut_sin),
    .out_valid (out_valid),
    .out_ch    (out_ch),
    .out_i     (out_i),
    .out_q     (out_q)
  );

endmodule

// File: rtl/ts_tuner_checks.sv
module ts_tuner_checks import tuner_pkg::*; #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_start,
  input logic                     issue_vld,
  input logic [CHW-1:0]           issue_ch,
  input logic                     ph_cleared,
  input logic signed [SAMP_W-1:0] lut_cos,
  input logic signed [SAMP_W-1:0] lut_sin,
  input logic                     out_valid,
  input logic [CHW-1:0]           out_ch
);

  assert_out_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(issue_vld, 3));

  assert_out_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_vld, 3) |-> out_ch == $past(issue_ch, 3));

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_vld) && $past(issue_ch) != CHW'(NCH - 1))
      |-> (issue_vld && issue_ch == CHW'($past(issue_ch) + 1'b1)));

  assert_busy_ignores_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && frame_start && issue_ch != CHW'(NCH - 1)) |=> issue_ch != '0);

  assert_clear_zero_angle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ph_cleared |=> (lut_cos == POS_MAX[SAMP_W-1:0] && lut_sin == '0));

endmodule

bind ts_tuner ts_tuner_checks #(.NCH(NCH), .CHW(CHW)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .issue_vld   (issue_vld),
  .issue_ch    (issue_ch),
  .ph_cleared  (ph_cleared),
  .lut_cos     (lut_cos),
  .lut_sin     (lut_sin),
  .out_valid   (out_valid),
  .out_ch      (out_ch)
);

// File: tb/test_ts_tuner.sv
module test_ts_tuner;
  localparam int NCH  = 8;
  localparam int NBIN = 64;
  localparam int CHW  = 3;
  localparam int BINW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic bin_we = 1'b0;
  logic [BINW-1:0] bin_idx = '0;
  logic signed [15:0] bin_i = '0;
  logic signed [15:0] bin_q = '0;
  logic cfg_we = 1'b0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [1:0] cfg_field = '0;
  logic [31:0] cfg_data = '0;
  logic out_valid;
  logic [CHW-1:0] out_ch;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;

  always #5 clk = ~clk;

  ts_tuner #(.NCH(NCH), .NBIN(NBIN)) i_ts_tuner (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .bin_we(bin_we), .bin_idx(bin_idx), .bin_i(bin_i), .bin_q(bin_q),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_ch(out_ch), .out_i(out_i), .out_q(out_q)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_acc = -1000;
  bit done = 1'b0;
  string cur_req = "R1";

  logic [31:0] m_step [NCH];
  logic [31:0] m_acc  [NCH];
  int          m_sel  [NCH];
  bit          m_clr  [NCH];
  int          b_i    [NBIN];
  int          b_q    [NBIN];
  int q_due[$];
  int q_ch[$];
  int q_i[$];
  int q_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int osc(int k, bit want_sin);
    real a;
    real v;
    a = 6.283185307179586 * real'(k) / 1024.0;
    v = (want_sin ? $sin(a) : $cos(a)) * 32767.0;
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  function automatic int shrink(longint s);
    longint t;
    longint r;
    t = s + 16384;
    if (t >= 0) r = t / 32768;
    else r = -((-t + 32767) / 32768);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  // expected results of one accepted sweep starting at edge e
  task automatic model_sweep(int e);
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] ph;
      int k;
      int cv;
      int sv;
      int si;
      int sq;
      ph = m_clr[c] ? 32'd0 : m_acc[c];
      m_clr[c] = 1'b0;
      k  = int'(ph >> 22);
      cv = osc(k, 1'b0);
      sv = osc(k, 1'b1);
      si = b_i[m_sel[c]];
      sq = b_q[m_sel[c]];
      q_due.push_back(e + c + 3);
      q_ch.push_back(c);
      q_i.push_back(shrink(longint'(si) * cv + longint'(sq) * sv));
      q_q.push_back(shrink(longint'(sq) * cv - longint'(si) * sv));
      m_acc[c] = ph + m_step[c];
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        if (out_valid !== 1'b1 ||
            {out_ch, out_i, out_q} !== {CHW'(q_ch[0]), 16'(q_i[0]), 16'(q_q[0])}) begin
          n_bad++;
          $display("FAIL %s cyc %0d: got v=%b ch=%0d i=%0d q=%0d expected v=1 ch=%0d i=%0d q=%0d",
                   cur_req, cyc, out_valid, out_ch, out_i, out_q, q_ch[0], q_i[0], q_q[0]);
        end
        void'(q_due.pop_front());
        void'(q_ch.pop_front());
        void'(q_i.pop_front());
        void'(q_q.pop_front());
      end else if (out_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL %s cyc %0d: got out_valid=%b expected 0", cur_req, cyc, out_valid);
      end
    end
  end

  task automatic put_bin(int k, int vi, int vq);
    @(negedge clk);
    bin_we = 1'b1; bin_idx = BINW'(k); bin_i = 16'(vi); bin_q = 16'(vq);
    b_i[k] = vi; b_q[k] = vq;
    @(negedge clk);
    bin_we = 1'b0;
  endtask

  task automatic put_cfg(int ch, int fld, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_field = 2'(fld); cfg_data = d;
    case (fld)
      0: m_step[ch] = d;
      1: m_sel[ch] = int'(d[BINW-1:0]);
      2: if (d[0]) m_clr[ch] = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive frame_start for the coming edge; model accepts per R3
  task automatic drive_fs();
    int e;
    frame_start = 1'b1;
    e = cyc + 1;
    if (e > last_acc + NCH) begin
      last_acc = e;
      model_sweep(e);
    end
  endtask

  task automatic run_frame();
    @(negedge clk);
    drive_fs();
    @(negedge clk);
    frame_start = 1'b0;
    repeat (NCH + 4) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no end of scenarios, expected completion");
      finish_up();
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_step[c] = '0; m_acc[c] = '0; m_sel[c] = 0; m_clr[c] = 1'b1;
    end
    // R1: reset state, no output while held and after release
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: fill the bin buffer, including full-scale bins for saturation
    cur_req = "R7";
    for (int k = 0; k < NBIN; k++) begin
      if (k == 5)      put_bin(k, 32767, 32767);
      else if (k == 6) put_bin(k, -32768, -32768);
      else             put_bin(k, ((k * 1237 + 500) % 60000) - 30000,
                                  ((k * 733 + 12000) % 60000) - 30000);
    end

    // R1: default configuration, phase 0 and bin 0 on every channel
    cur_req = "R1 R2 R10";
    run_frame();

    // R8: program steps and bin selectors; R7 masks upper selector bits
    cur_req = "R8 R7";
    put_cfg(0, 0, 32'h4000_0000); put_cfg(0, 1, 32'd3);
    put_cfg(1, 0, 32'h2000_0000); put_cfg(1, 1, 32'd5);
    put_cfg(2, 0, 32'h0040_0000); put_cfg(2, 1, 32'd6);
    put_cfg(3, 0, 32'hFFC0_0000); put_cfg(3, 1, 32'd10);
    put_cfg(4, 0, 32'h8000_0001); put_cfg(4, 1, 32'hFFFF_FF07);
    put_cfg(5, 0, 32'h1234_5678); put_cfg(5, 1, 32'd63);
    put_cfg(6, 0, 32'h0010_0000); put_cfg(6, 1, 32'd1);
    put_cfg(7, 0, 32'hC000_0000); put_cfg(7, 1, 32'd20);

    // R4 R5 R6: phase advance with wrap and residue, table, mixer saturation
    cur_req = "R4 R5 R6";
    repeat (9) run_frame();

    // R3: extra starts during a sweep are dropped
    cur_req = "R3";
    @(negedge clk); drive_fs();
    for (int n = 0; n < 4; n++) begin @(negedge clk); drive_fs(); end
    @(negedge clk); frame_start = 1'b0;
    repeat (NCH + 4) @(negedge clk);

    // R3: held high gives back-to-back sweeps every NCH+1 edges
    cur_req = "R3 R2";
    for (int n = 0; n < 3 * (NCH + 1) + 2; n++) begin @(negedge clk); drive_fs(); end
    @(negedge clk); frame_start = 1'b0;
    repeat (NCH + 4) @(negedge clk);

    // R8: field code 3 changes nothing
    cur_req = "R8";
    put_cfg(0, 3, 32'hFFFF_FFFF);
    put_cfg(1, 3, 32'h0000_0000);
    run_frame();

    // R9: clear restarts phase at zero; clear with bit 0 low is inert
    cur_req = "R9";
    put_cfg(5, 2, 32'd1);
    put_cfg(2, 2, 32'd1);
    put_cfg(3, 2, 32'hFFFF_FFFE);
    run_frame();
    run_frame();

    // R7 R8: new bin contents and a new selector take effect next slot
    cur_req = "R7 R8";
    put_bin(3, -12345, 23456);
    put_bin(0, 30000, -30000);
    put_cfg(6, 1, 32'd0);
    put_cfg(7, 0, 32'h0000_0001);
    run_frame();
    run_frame();

    cur_req = "R2";
    repeat (6) @(negedge clk);
    if (q_due.size() != 0) begin
      n_bad++;
      $display("FAIL R2: got %0d outputs still pending, expected 0", q_due.size());
    end
    finish_up();
  end

endmodule